// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block is the host-side master for a small 128-byte serial EEPROM that uses a four-wire link: an active-low chip select, a serial clock that idles high, a data line toward the memory and a data line back from it. A client asks for one operation at a time on a simple command port: read a byte, program a byte, erase the whole array, or turn write protection off or on. The block builds the serial frame, generates the serial clock from the system clock with a programmable divider, and collects read data. It returns the result with a one-cycle done pulse.

After a program or erase, the memory keeps working internally for several milliseconds. The controller does not wait for a fixed time. It sends status frames one after another and reads the ready level the memory returns, and it finishes once that level is high. If the memory still reports busy once a cycle budget has run out, the command ends with an error flag. A per-command option sends a protect-off frame first, so that a write works whatever the protection state of the memory.

Top module: `seep_host`

## Requirements
- R1: While reset is held and after it is released, chip select and the serial clock are high, the command port is ready, and done and error are low.
- R2: Chip select stays high for at least CS_GAP system clocks before every frame. The serial clock is high whenever chip select is high, and also at the moment chip select falls or rises.
- R3: Each serial clock low phase lasts exactly HALF_DIV system clocks and each high phase inside a frame at least HALF_DIV. Data toward the memory changes only at falling edges. The return line is sampled at each rising edge.
- R4: Every frame sends address bits A0..A6, then a 0, then opcode bits C0..C3, then four 0s. Opcodes, as a 4-bit value with C0 in bit 0, are: read 0001, program 0110, erase 1100, status 1101, protect-off 1001, protect-on 1011. The address field is zero for erase, status and protect frames. A program frame then sends the data D0..D7, for 24 clocks. Read is 24 clocks, status 17, and all others 16.
- R5: A read returns the 8 bits sampled on serial clocks 17 to 24 on cmd_rdata, with the first sampled bit in bit 0.
- R6: After a program or erase frame, status frames follow until the level sampled at the 17th rising edge is high. The command then completes with error low.
- R7: At the end of each status frame that reads busy, if at least TIMEOUT system clocks have passed since the polling began, the command completes with cmd_err high.
- R8: With cmd_auto_unlock set, a protect-off frame comes before a program or erase. Without it, a program or erase while the memory is protected leaves the memory contents unchanged.
- R9: cmd_op encoding: 0 read, 1 program, 2 erase, 3 protect-off, 4 protect-on, 5 to 7 read. A start is taken only while cmd_ready is high. cmd_ready then drops on the next cycle and stays low until done, and a start while it is low has no effect.
- R10: cmd_done is a single-cycle pulse in the cycle cmd_ready returns high. cmd_rdata changes only with cmd_done. cmd_err holds until the next accepted command.
- R11: Protect-off and protect-on commands send one 16-clock frame and complete without status polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start strobe for one command |
| cmd_op | input | 3 | Operation code (see R9) |
| cmd_addr | input | 7 | Byte address |
| cmd_wdata | input | 8 | Byte to program |
| cmd_auto_unlock | input | 1 | Send protect-off before program or erase |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Status polling timed out |
| cmd_rdata | output | 8 | Byte returned by the last read |
| sp_cs_n | output | 1 | Serial chip select, active low |
| sp_clk | output | 1 | Serial clock, idles high |
| sp_di | output | 1 | Serial data toward the memory |
| sp_do | input | 1 | Serial data from the memory |

## Verification
The assertions check the link timing on every cycle: clock high while select is high, the select-high gap before each frame, and the exact length of each clock low phase. They also check the command handshake: ready drops after an accepted start, ready comes back only with done, done lasts one cycle, and read data changes only with done. The bench scenarios must show frame contents, read data order, polling until ready, the timeout error, protection and auto-unlock effects, and rejected starts. To do this they drive a behavioural memory and read its contents back through the port.

// File: rtl/seep_pkg.sv
`timescale 1ns/1ps
// Package: shared types and protocol constants for the serial EEPROM host.
// Assumes a fixed 7-bit address, 8-bit data protocol; opcode bit 0 is C0.
package seep_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = 24;
    localparam int NB_W      = $clog2(FRAME_MAX + 1);

    // Opcode fields C0..C3 with C0 in bit 0 (sent first).
    localparam logic [3:0] CODE_READ  = 4'b0001;
    localparam logic [3:0] CODE_PROG  = 4'b0110;
    localparam logic [3:0] CODE_ERASE = 4'b1100;
    localparam logic [3:0] CODE_STAT  = 4'b1101;
    localparam logic [3:0] CODE_UNLK  = 4'b1001;
    localparam logic [3:0] CODE_LOCK  = 4'b1011;

    // Frame lengths in serial clocks.
    localparam logic [NB_W-1:0] LEN_SHORT = NB_W'(16);
    localparam logic [NB_W-1:0] LEN_STAT  = NB_W'(17);
    localparam logic [NB_W-1:0] LEN_LONG  = NB_W'(24);

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_ERASE  = 3'd2,
        OP_UNLOCK = 3'd3,
        OP_LOCK   = 3'd4
    } seep_op_e;

    typedef enum logic [1:0] {
        FK_MAIN   = 2'd0,
        FK_UNLOCK = 2'd1,
        FK_POLL   = 2'd2
    } seep_kind_e;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_GAP   = 3'd1,
        FS_SETUP = 3'd2,
        FS_LOW   = 3'd3,
        FS_HIGH  = 3'd4
    } seep_fstate_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_UNLOCK = 2'd1,
        SQ_MAIN   = 2'd2,
        SQ_POLL   = 2'd3
    } seep_sstate_e;

endpackage

// File: rtl/seep_framer.sv
`timescale 1ns/1ps
// Module: seep_framer
// Builds the bit vector and length of one serial frame from the frame kind
// and the latched command. Purely combinational.
// Assumes: bit i of f_tx is sent on serial clock i+1.
module seep_framer
    import seep_pkg::*;
(
    input  seep_kind_e              kind,
    input  seep_op_e                op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [FRAME_MAX-1:0]    f_tx,
    output logic [NB_W-1:0]         f_nbits
);

    logic [3:0] code;
    logic       use_addr;
    logic       use_data;

    // Select opcode, length and which fields are populated (R4).
    always_comb begin
        code     = CODE_READ;
        use_addr = 1'b0;
        use_data = 1'b0;
        f_nbits  = LEN_SHORT;
        case (kind)
            FK_UNLOCK: begin
                code    = CODE_UNLK;
                f_nbits = LEN_SHORT;
            end
            FK_POLL: begin
                code    = CODE_STAT;
                f_nbits = LEN_STAT;
            end
            default: begin
                case (op)
                    OP_WRITE: begin
                        code     = CODE_PROG;
                        use_addr = 1'b1;
                        use_data = 1'b1;
                        f_nbits  = LEN_LONG;
                    end
                    OP_ERASE:  code = CODE_ERASE;
                    OP_UNLOCK: code = CODE_UNLK;
                    OP_LOCK:   code = CODE_LOCK;
                    default: begin
                        code     = CODE_READ;
                        use_addr = 1'b1;
                        f_nbits  = LEN_LONG;
                    end
                endcase
            end
        endcase
    end

    // Place fields: address LSB first, a zero, C0..C3, four zeros, data D0 first.
    always_comb begin
        f_tx         = '0;
        f_tx[6:0]    = use_addr ? addr : '0;
        f_tx[11:8]   = code;
        f_tx[23:16]  = use_data ? wdata : '0;
    end

endmodule

// File: rtl/seep_frame.sv
`timescale 1ns/1ps
// Module: seep_frame
// Runs one serial frame: select-high gap, select low with clock high for a
// setup half period, then nbits clock periods (low half launches a bit,
// rising edge samples the return line), then select high.
// Assumes HALF_DIV >= 1 and CS_GAP >= 1; f_start only while idle.
module seep_frame
    import seep_pkg::*;
#(
    parameter int HALF_DIV = 50,
    parameter int CS_GAP   = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  f_start,
    input  logic [FRAME_MAX-1:0]  f_tx,
    input  logic [NB_W-1:0]       f_nbits,
    input  logic                  sp_do,
    output logic                  sp_cs_n,
    output logic                  sp_clk,
    output logic                  sp_di,
    output logic                  f_done,
    output logic [DATA_W-1:0]     f_rx
);

    localparam int WAIT_MAX = (HALF_DIV > CS_GAP) ? HALF_DIV : CS_GAP;
    localparam int TW       = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(CS_GAP - 1);

    seep_fstate_e         st;
    logic [TW-1:0]        tmr;
    logic [NB_W-1:0]      idx;
    logic [NB_W-1:0]      nb_q;
    logic [FRAME_MAX-1:0] tx_q;
    logic [DATA_W-1:0]    rx_q;
    logic                 tmr_zero;

    assign tmr_zero = (tmr == '0);

    // Frame state machine with one shared phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FS_IDLE;
            tmr    <= '0;
            idx    <= '0;
            nb_q   <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            f_done <= 1'b0;
        end else begin
            f_done <= 1'b0;
            case (st)
                FS_IDLE: begin
                    if (f_start) begin
                        st   <= FS_GAP;
                        tmr  <= GAP_LD;
                        idx  <= '0;
                        tx_q <= f_tx;
                        nb_q <= f_nbits;
                    end
                end
                FS_GAP: begin
                    if (tmr_zero) begin
                        st  <= FS_SETUP;
                        tmr <= HALF_LD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                FS_SETUP: begin
                    if (tmr_zero) begin
                        st  <= FS_LOW;
                        tmr <= HALF_LD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                FS_LOW: begin
                    if (tmr_zero) begin
                        st   <= FS_HIGH;
                        tmr  <= HALF_LD;
                        rx_q <= {sp_do, rx_q[DATA_W-1:1]};
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                FS_HIGH: begin
                    if (tmr_zero) begin
                        if (idx == nb_q - 1'b1) begin
                            st     <= FS_IDLE;
                            f_done <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= FS_LOW;
                            tmr <= HALF_LD;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end

    // Pin levels follow the frame state; data holds over both halves of a bit.
    always_comb begin
        sp_cs_n = (st == FS_IDLE) || (st == FS_GAP);
        sp_clk  = (st != FS_LOW);
        sp_di   = ((st == FS_LOW) || (st == FS_HIGH)) ? tx_q[idx] : 1'b0;
    end

    assign f_rx = rx_q;

endmodule

// File: rtl/seep_seq.sv
`timescale 1ns/1ps
// Module: seep_seq
// Command sequencer: accepts one command, orders the optional protect-off
// frame, the main frame and the status polling frames, and reports done,
// error and read data. Timeout is judged at the end of each status frame.
// Assumes the frame engine pulses f_done once per f_start.
module seep_seq
    import seep_pkg::*;
#(
    parameter int TIMEOUT = 2000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_wdata,
    input  logic                cmd_auto_unlock,
    input  logic                f_done,
    input  logic [DATA_W-1:0]   f_rx,
    output logic                f_start,
    output seep_kind_e          f_kind,
    output seep_op_e            op_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [DATA_W-1:0]   wdata_q,
    output logic                cmd_ready,
    output logic                cmd_done,
    output logic                cmd_err,
    output logic [DATA_W-1:0]   cmd_rdata
);

    localparam int TOW = $clog2(TIMEOUT + 1);
    localparam logic [TOW-1:0] TO_MAX = TOW'(TIMEOUT);

    seep_sstate_e   st;
    seep_op_e       op_in;
    logic           start_mod;
    logic           op_mod;
    logic [TOW-1:0] tcnt;

    // Decode the raw port code; reserved values act as read (R9).
    always_comb begin
        case (cmd_op)
            3'd1:    op_in = OP_WRITE;
            3'd2:    op_in = OP_ERASE;
            3'd3:    op_in = OP_UNLOCK;
            3'd4:    op_in = OP_LOCK;
            default: op_in = OP_READ;
        endcase
    end

    assign start_mod = (op_in == OP_WRITE) || (op_in == OP_ERASE);
    assign op_mod    = (op_q == OP_WRITE) || (op_q == OP_ERASE);
    assign cmd_ready = (st == SQ_IDLE);

    // Command-level sequencing, polling and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            f_start   <= 1'b0;
            f_kind    <= FK_MAIN;
            op_q      <= OP_READ;
            addr_q    <= '0;
            wdata_q   <= '0;
            cmd_done  <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_rdata <= '0;
            tcnt      <= '0;
        end else begin
            f_start  <= 1'b0;
            cmd_done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (cmd_start) begin
                        op_q    <= op_in;
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                        cmd_err <= 1'b0;
                        f_start <= 1'b1;
                        if (start_mod && cmd_auto_unlock) begin
                            f_kind <= FK_UNLOCK;
                            st     <= SQ_UNLOCK;
                        end else begin
                            f_kind <= FK_MAIN;
                            st     <= SQ_MAIN;
                        end
                    end
                end
                SQ_UNLOCK: begin
                    if (f_done) begin
                        f_start <= 1'b1;
                        f_kind  <= FK_MAIN;
                        st      <= SQ_MAIN;
                    end
                end
                SQ_MAIN: begin
                    if (f_done) begin
                        if (op_mod) begin
                            f_start <= 1'b1;
                            f_kind  <= FK_POLL;
                            tcnt    <= '0;
                            st      <= SQ_POLL;
                        end else begin
                            if (op_q == OP_READ) begin
                                cmd_rdata <= f_rx;
                            end
                            cmd_done <= 1'b1;
                            st       <= SQ_IDLE;
                        end
                    end
                end
                SQ_POLL: begin
                    if (tcnt != TO_MAX) begin
                        tcnt <= tcnt + 1'b1;
                    end
                    if (f_done) begin
                        if (f_rx[DATA_W-1]) begin
                            cmd_done <= 1'b1;
                            st       <= SQ_IDLE;
                        end else if (tcnt == TO_MAX) begin
                            cmd_err  <= 1'b1;
                            cmd_done <= 1'b1;
                            st       <= SQ_IDLE;
                        end else begin
                            f_start <= 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seep_host.sv
`timescale 1ns/1ps
// Module: seep_host (top)
// Serial EEPROM host controller: command port in, four-wire serial link out.
// Assumes HALF_DIV chosen so the serial clock stays at or below 1 MHz and
// CS_GAP covers the memory's minimum select-high time.
module seep_host
    import seep_pkg::*;
#(
    parameter int HALF_DIV = 50,
    parameter int CS_GAP   = 200,
    parameter int TIMEOUT  = 2000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [2:0]  cmd_op,
    input  logic [6:0]  cmd_addr,
    input  logic [7:0]  cmd_wdata,
    input  logic        cmd_auto_unlock,
    output logic        cmd_ready,
    output logic        cmd_done,
    output logic        cmd_err,
    output logic [7:0]  cmd_rdata,
    output logic        sp_cs_n,
    output logic        sp_clk,
    output logic        sp_di,
    input  logic        sp_do
);

    logic                  f_start;
    logic                  f_done;
    seep_kind_e            f_kind;
    seep_op_e              op_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [FRAME_MAX-1:0]  f_tx;
    logic [NB_W-1:0]       f_nbits;
    logic [DATA_W-1:0]     f_rx;

    seep_seq #(
        .TIMEOUT (TIMEOUT)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_start       (cmd_start),
        .cmd_op          (cmd_op),
        .cmd_addr        (cmd_addr),
        .cmd_wdata       (cmd_wdata),
        .cmd_auto_unlock (cmd_auto_unlock),
        .f_done          (f_done),
        .f_rx            (f_rx),
        .f_start         (f_start),
        .f_kind          (f_kind),
        .op_q            (op_q),
        .addr_q          (addr_q),
        .wdata_q         (wdata_q),
        .cmd_ready       (cmd_ready),
        .cmd_done        (cmd_done),
        .cmd_err         (cmd_err),
        .cmd_rdata       (cmd_rdata)
    );

    seep_framer u_bld (
        .kind    (f_kind),
        .op      (op_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .f_tx    (f_tx),
        .f_nbits (f_nbits)
    );

    seep_frame #(
        .HALF_DIV (HALF_DIV),
        .CS_GAP   (CS_GAP)
    ) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .f_start (f_start),
        .f_tx    (f_tx),
        .f_nbits (f_nbits),
        .sp_do   (sp_do),
        .sp_cs_n (sp_cs_n),
        .sp_clk  (sp_clk),
        .sp_di   (sp_di),
        .f_done  (f_done),
        .f_rx    (f_rx)
    );

endmodule

// File: rtl/seep_host_chk.sv
`timescale 1ns/1ps
// Module: seep_host_chk
// Protocol and handshake checker bound to seep_host. Counters measure the
// select-high gap and clock low phase so no deep history is needed.
module seep_host_chk #(
    parameter int HALF_DIV = 50,
    parameter int CS_GAP   = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       cmd_ready,
    input logic       cmd_done,
    input logic [7:0] cmd_rdata,
    input logic       sp_cs_n,
    input logic       sp_clk
);

    logic [15:0] low_cnt;
    logic [15:0] gap_cnt;

    // Count consecutive cycles with the serial clock low.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (sp_clk)            low_cnt <= '0;
        else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
    end

    // Count consecutive cycles with chip select high.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_cnt <= '0;
        else if (!sp_cs_n)          gap_cnt <= '0;
        else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end

    // R2
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_cs_n |-> sp_clk);

    // R2
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sp_cs_n) |-> (gap_cnt >= 16'(CS_GAP)));

    // R3
    low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sp_clk) |-> (low_cnt == 16'(HALF_DIV)));

    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_ready) |=> !cmd_ready);

    // R9
    ready_idle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> sp_cs_n);

    // R10
    ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> cmd_done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> $stable(cmd_rdata));

endmodule

bind seep_host seep_host_chk #(
    .HALF_DIV (HALF_DIV),
    .CS_GAP   (CS_GAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_ready (cmd_ready),
    .cmd_done  (cmd_done),
    .cmd_rdata (cmd_rdata),
    .sp_cs_n   (sp_cs_n),
    .sp_clk    (sp_clk)
);

// File: tb/seep_host_tb.sv
`timescale 1ns/1ps
// Directed bench for seep_host with a behavioural serial memory model.
module seep_host_tb;

    localparam int HALF = 2;
    localparam int GAP  = 5;
    localparam int TO   = 2000;
    localparam int WLAT = 300;

    // Opcode values from R4, C0 in bit 0.
    localparam logic [3:0] C_RD  = 4'b0001;
    localparam logic [3:0] C_PR  = 4'b0110;
    localparam logic [3:0] C_ER  = 4'b1100;
    localparam logic [3:0] C_ST  = 4'b1101;
    localparam logic [3:0] C_UL  = 4'b1001;
    localparam logic [3:0] C_LK  = 4'b1011;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    always #2.5 clk = ~clk;

    logic       cmd_start = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_auto_unlock = 1'b0;
    logic       cmd_ready, cmd_done, cmd_err;
    logic [7:0] cmd_rdata;
    logic       sp_cs_n, sp_clk, sp_di;
    logic       mdo = 1'b1;

    seep_host #(.HALF_DIV(HALF), .CS_GAP(GAP), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_auto_unlock(cmd_auto_unlock), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
        .sp_cs_n(sp_cs_n), .sp_clk(sp_clk), .sp_di(sp_di), .sp_do(mdo)
    );

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // ---------------- memory model ----------------
    int         cyc = 0;
    int         busy_until = 0;
    bit         stuck = 0;
    logic [7:0] mem [128];
    logic [23:0] rxf = '0;
    int         bitn = 0;
    bit         wen = 0;
    int         frames = 0, polls = 0, last_len = 0, fmt_bad = 0;

    always @(posedge clk) cyc++;

    // Frame capture and decode at select rise; reset restores model state.
    always @(negedge rst_n or posedge sp_cs_n or posedge sp_clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] = pat(i);
            wen = 0; busy_until = 0; bitn = 0; rxf = '0;
        end else if (sp_cs_n === 1'b1) begin
            if (bitn > 0) begin
                frames++;
                last_len = bitn;
                if (rxf[7] || rxf[15:12] != 4'b0) fmt_bad++;
                if (rxf[11:8] == C_ST) begin
                    polls++;
                    if (bitn != 17) fmt_bad++;
                end else if (!((cyc < busy_until) || stuck)) begin
                    case (rxf[11:8])
                        C_UL: if (bitn == 16) wen = 1;
                        C_LK: if (bitn == 16) wen = 0;
                        C_PR: if (bitn == 24 && wen) begin
                            mem[rxf[6:0]] = rxf[23:16];
                            busy_until = cyc + WLAT;
                        end
                        C_ER: if (bitn == 16 && wen) begin
                            for (int i = 0; i < 128; i++) mem[i] = 8'h00;
                            busy_until = cyc + WLAT;
                        end
                        default: ;
                    endcase
                end
            end
            bitn = 0;
            rxf = '0;
        end else if (sp_cs_n === 1'b0) begin
            if (bitn < 24) rxf[bitn] = sp_di;
            bitn++;
        end
    end

    // Return line driven at falling serial clock edges.
    always @(negedge sp_clk) begin
        if (sp_cs_n === 1'b0) begin
            if (bitn >= 16 && bitn < 24 && rxf[11:8] == C_RD)
                mdo = mem[rxf[6:0]][bitn-16];
            else if (bitn >= 16 && rxf[11:8] == C_ST)
                mdo = !((cyc < busy_until) || stuck);
            else
                mdo = 1'b1;
        end
    end

    // ---------------- link monitor (R2, R3) ----------------
    int  gap_n = 0, low_n = 0, proto_bad = 0;
    logic prev_cs = 1'b1, prev_clk = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sp_cs_n && !sp_clk) proto_bad++;
            if (!sp_cs_n && prev_cs && (gap_n < GAP || !sp_clk)) proto_bad++;
            if (sp_cs_n && !prev_cs && !prev_clk) proto_bad++;
            if (sp_clk && !prev_clk && low_n != HALF) proto_bad++;
        end
        gap_n = sp_cs_n ? gap_n + 1 : 0;
        low_n = sp_clk ? 0 : low_n + 1;
        prev_cs = sp_cs_n;
        prev_clk = sp_clk;
    end

    // ---------------- tasks ----------------
    logic [7:0] got_rd;
    logic       got_err;
    int         done_cyc;

    task automatic run(input logic [2:0] op, input logic [6:0] a,
                       input logic [7:0] d, input logic au);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_auto_unlock = au;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!cmd_done) @(negedge clk);
        got_rd = cmd_rdata; got_err = cmd_err; done_cyc = cyc;
        @(negedge clk);
        chk("R10", "done single cycle", int'(cmd_done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "cs_n in reset", int'(sp_cs_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "cs_n", int'(sp_cs_n), 1);
        chk("R1", "sclk", int'(sp_clk), 1);
        chk("R1", "ready", int'(cmd_ready), 1);
        chk("R1", "done/err", int'({cmd_done, cmd_err}), 0);
    endtask

    task automatic t_protect();
        run(3'd1, 7'd9, 8'hC3, 1'b0);
        chk("R8", "protected write err", int'(got_err), 0);
        run(3'd0, 7'd9, 8'h00, 1'b0);
        chk("R8", "protected write ignored", int'(got_rd), int'(pat(9)));
    endtask

    task automatic t_unlock_write();
        int f0, p0;
        f0 = frames; p0 = polls;
        run(3'd3, 7'd0, 8'h00, 1'b0);
        chk("R11", "unlock one frame", frames - f0, 1);
        chk("R11", "unlock length", last_len, 16);
        chk("R11", "unlock no polling", polls - p0, 0);
        p0 = polls;
        run(3'd1, 7'h21, 8'h96, 1'b0);
        chk("R6", "polls after program >=2", int'((polls - p0) >= 2), 1);
        chk("R6", "done after ready", int'(done_cyc >= busy_until), 1);
        chk("R6", "no error", int'(got_err), 0);
        run(3'd0, 7'h21, 8'h00, 1'b0);
        chk("R4", "program readback", int'(got_rd), 8'h96);
        chk("R4", "read length", last_len, 24);
    endtask

    task automatic t_reads();
        run(3'd0, 7'd0, 8'h00, 1'b0);
        chk("R5", "read addr 0", int'(got_rd), int'(pat(0)));
        run(3'd0, 7'd127, 8'h00, 1'b0);
        chk("R5", "read addr 127", int'(got_rd), int'(pat(127)));
        run(3'd6, 7'd85, 8'h00, 1'b0);
        chk("R9", "reserved op reads", int'(got_rd), int'(pat(85)));
    endtask

    task automatic t_lock_auto();
        int f0, p0;
        run(3'd4, 7'd0, 8'h00, 1'b0);
        chk("R11", "lock length", last_len, 16);
        f0 = frames; p0 = polls;
        run(3'd1, 7'h40, 8'h5C, 1'b1);
        chk("R8", "auto unlock frames", frames - f0, 2 + (polls - p0));
        run(3'd0, 7'h40, 8'h00, 1'b0);
        chk("R8", "auto unlock write", int'(got_rd), 8'h5C);
    endtask

    task automatic t_erase();
        run(3'd4, 7'd0, 8'h00, 1'b0);
        run(3'd2, 7'd0, 8'h00, 1'b0);
        run(3'd0, 7'h40, 8'h00, 1'b0);
        chk("R8", "protected erase ignored", int'(got_rd), 8'h5C);
        run(3'd2, 7'd0, 8'h00, 1'b1);
        chk("R6", "erase done after ready", int'(done_cyc >= busy_until), 1);
        run(3'd0, 7'h40, 8'h00, 1'b0);
        chk("R6", "erased 0x40", int'(got_rd), 0);
        run(3'd0, 7'd127, 8'h00, 1'b0);
        chk("R6", "erased 127", int'(got_rd), 0);
    endtask

    task automatic t_busy_reject();
        int f0, p0;
        logic [7:0] rd0;
        rd0 = cmd_rdata;
        f0 = frames; p0 = polls;
        while (!cmd_ready) @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 7'h11; cmd_wdata = 8'h3E; cmd_auto_unlock = 1'b1;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9", "ready low while busy", int'(cmd_ready), 0);
        cmd_op = 3'd0; cmd_addr = 7'h05; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!cmd_done) @(negedge clk);
        chk("R9", "ready with done", int'(cmd_ready), 1);
        repeat (200) @(negedge clk);
        chk("R9", "rejected start no frame", frames - f0, 2 + (polls - p0));
        chk("R10", "rdata held", int'(cmd_rdata), int'(rd0));
        run(3'd0, 7'h11, 8'h00, 1'b0);
        chk("R9", "write landed", int'(got_rd), 8'h3E);
    endtask

    task automatic t_timeout();
        int c0;
        stuck = 1;
        c0 = cyc;
        run(3'd1, 7'h22, 8'h77, 1'b1);
        chk("R7", "timeout error", int'(got_err), 1);
        chk("R7", "not before budget", int'((done_cyc - c0) >= TO), 1);
        repeat (5) @(negedge clk);
        chk("R10", "err held", int'(cmd_err), 1);
        stuck = 0;
        run(3'd0, 7'd3, 8'h00, 1'b0);
        chk("R10", "err cleared", int'(got_err), 0);
    endtask

    task automatic t_link();
        chk("R2", "link timing violations", proto_bad, 0);
        chk("R4", "frame format violations", fmt_bad, 0);
    endtask

    initial begin
        t_reset();
        t_protect();
        t_unlock_write();
        t_reads();
        t_lock_auto();
        t_erase();
        t_busy_reject();
        t_timeout();
        t_link();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nbad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

endmodule